// File: doc/BRIEF.md
# Reference and Microphone Delay Alignment Controller

This block lines up a loudspeaker reference stream and a microphone stream in time, so that an echo canceller further down receives them matched. The two streams of 16-bit signed samples arrive together on one shared sample strobe. One of the streams, picked by the host, is delayed by a programmable number of samples, from 0 to 2400 (0 to 150 ms at 16 kHz). The delay line is a circular buffer. The other stream passes through with only one register of latency.

A mode controller decides when the delay may change. In continuous mode it keeps asking an external delay estimator for results and applies every answer. In triggered mode it stays idle until the host asks for an estimate. In start-up mode, the reset default, it asks once right after reset, applies the answer and then holds it. In every mode the host can write a fixed delay directly. The estimator sits outside the block and is reached through a request/acknowledge handshake.

Top module: `ref_mic_aligner`

## Requirements
- R1: Delay values from the estimator or the host that exceed 2400 are clamped to 2400. Every value from 0 to 2400 is applied exactly as given.
- R2: `cfg_sel` picks the delayed stream: 0 delays the reference, 1 delays the microphone. The other stream's output equals its input from the previous strobe.
- R3: The delayed output for a strobe carries the selected input from exactly D strobes earlier. D is the delay in force at that strobe. When fewer than D samples have been written since reset, the output is 0.
- R4: When `cfg_mode` is 2'b01 (continuous), `est_req` is high from the next cycle on. Every `est_ack` while `est_req` is high loads `est_val`.
- R5: When `cfg_mode` is 2'b10 (triggered), `est_req` stays low after reset. It rises the cycle after a `trig` pulse and falls the cycle after the answering `est_ack`, and that answer is loaded.
- R6: When `cfg_mode` is 2'b00 (start-up), `est_req` rises on the first cycle after reset. It falls after one `est_ack`, whose value is loaded, and is raised again only by `trig`.
- R7: Outside continuous mode, the held delay changes only on `fix_wr` or on an `est_ack` while `est_req` is high. An `est_ack` while `est_req` is low has no effect.
- R8: `fix_wr` loads `fix_val` (clamped) in any mode. The new delay applies from the next strobe after the write.
- R9: `cur_dly` reads 0 after reset and shows the delay used by the most recent strobe.
- R10: `out_vld` is high exactly one cycle after each cycle in which `smp_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Shared sample strobe for both streams |
| ref_in | input | 16 | Loudspeaker reference sample |
| mic_in | input | 16 | Microphone sample |
| out_vld | output | 1 | Output samples valid |
| ref_out | output | 16 | Aligned reference sample |
| mic_out | output | 16 | Aligned microphone sample |
| cfg_mode | input | 2 | 00 start-up, 01 continuous, 10 triggered |
| cfg_sel | input | 1 | 0 delay reference, 1 delay microphone |
| fix_wr | input | 1 | Host fixed-delay write strobe |
| fix_val | input | 12 | Host fixed delay in samples |
| trig | input | 1 | Host estimate trigger pulse |
| est_req | output | 1 | Estimate request, also the busy flag |
| est_ack | input | 1 | Estimator result strobe |
| est_val | input | 12 | Estimated delay in samples |
| cur_dly | output | 12 | Delay applied to the latest sample |

## Verification
The assertions assume the estimator answers only with a single-cycle `est_ack` pulse. They also assume `cfg_mode` never takes the value 2'b11, and that `cfg_sel` is changed only together with a reset, because changing it live mixes the two streams in the buffer. The stimulus follows these rules: it sets the mode and the stream select while reset is held, and it drives each acknowledge for one cycle only. The one exception is a deliberate stray acknowledge sent while no request is pending, which exercises the ignore path. Samples are sent every other cycle, so each result can be matched to its strobe in the scoreboard.

// File: rtl/ref_mic_aligner.sv
module ref_mic_aligner #(
  parameter int W       = 16,
  parameter int MAX_DLY = 2400,
  parameter int DW      = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_en,
  input  logic [W-1:0]  ref_in,
  input  logic [W-1:0]  mic_in,
  output logic          out_vld,
  output logic [W-1:0]  ref_out,
  output logic [W-1:0]  mic_out,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_sel,
  input  logic          fix_wr,
  input  logic [DW-1:0] fix_val,
  input  logic          trig,
  output logic          est_req,
  input  logic          est_ack,
  input  logic [DW-1:0] est_val,
  output logic [DW-1:0] cur_dly
);
  localparam int DEPTH = MAX_DLY + 1;
  localparam int AW = $clog2(DEPTH);
  localparam logic [1:0] M_BOOT = 2'b00;
  localparam logic [1:0] M_AUTO = 2'b01;
  localparam logic [1:0] M_MAN  = 2'b10;
  localparam logic [DW-1:0] DMAX = DW'(MAX_DLY);

  function automatic logic [DW-1:0] clamp(input logic [DW-1:0] v);
    return (v > DMAX) ? DMAX : v;
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [DW-1:0] pend, fill;
  logic          boot;
  logic [W-1:0]  src, dly_smp;
  int unsigned   rsum;

  assign src = cfg_sel ? mic_in : ref_in;

  always_comb begin
    rsum = 32'(wptr) + 32'(DEPTH) - 32'(pend);
    if (rsum >= 32'(DEPTH)) rsum = rsum - 32'(DEPTH);
    rptr = AW'(rsum);
  end

  assign dly_smp = (pend == '0) ? src : (fill < pend) ? '0 : mem[rptr];

  always_ff @(posedge clk)
    if (smp_en) mem[wptr] <= src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      fill    <= '0;
      out_vld <= 1'b0;
      ref_out <= '0;
      mic_out <= '0;
      cur_dly <= '0;
    end else begin
      out_vld <= smp_en;
      if (smp_en) begin
        wptr    <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
        fill    <= (fill == DMAX) ? fill : fill + 1'b1;
        ref_out <= cfg_sel ? ref_in : dly_smp;
        mic_out <= cfg_sel ? dly_smp : mic_in;
        cur_dly <= pend;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot    <= 1'b1;
      est_req <= 1'b0;
      pend    <= '0;
    end else begin
      boot <= 1'b0;
      if (cfg_mode == M_AUTO)
        est_req <= 1'b1;
      else if (est_ack && est_req)
        est_req <= 1'b0;
      else if ((boot && cfg_mode == M_BOOT) || trig)
        est_req <= 1'b1;
      if (fix_wr)
        pend <= clamp(fix_val);
      else if (est_ack && est_req)
        pend <= clamp(est_val);
    end
  end

  // R1
  dly_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= DMAX);
  // R10
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en |=> out_vld);
  // R10
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> !out_vld);
  // R2
  mic_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && !cfg_sel) |=> mic_out == $past(mic_in));
  // R2
  ref_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && cfg_sel) |=> ref_out == $past(ref_in));
  // R4
  auto_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode == M_AUTO |=> est_req);
  // R5
  man_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == M_MAN && !est_req && !trig) |=> !est_req);
  // R7
  hold_dly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fix_wr && !(est_ack && est_req)) |=> $stable(pend));
endmodule

// File: tb/ref_mic_aligner_test.sv
module ref_mic_aligner_test;
  logic clk = 0, rst_n = 0, smp_en = 0, cfg_sel = 0, fix_wr = 0, trig = 0, est_ack = 0;
  logic [15:0] ref_in = 0, mic_in = 0;
  logic [1:0] cfg_mode = 2'b00;
  logic [11:0] fix_val = 0, est_val = 0;
  logic out_vld, est_req;
  logic [15:0] ref_out, mic_out;
  logic [11:0] cur_dly;
  int errors = 0, checks = 0, mdly = 0, seq = 0;
  logic [15:0] hist[$];
  logic [31:0] expq[$];

  always #2 clk = ~clk;

  ref_mic_aligner uut (.clk, .rst_n, .smp_en, .ref_in, .mic_in, .out_vld, .ref_out, .mic_out,
    .cfg_mode, .cfg_sel, .fix_wr, .fix_val, .trig, .est_req, .est_ack, .est_val, .cur_dly);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clampv(input int v);
    return (v > 2400) ? 2400 : v;
  endfunction

  always @(negedge clk) if (rst_n && out_vld) begin
    if (expq.size() == 0) chk(0, "R10 unexpected out_vld", 1, 0);
    else begin
      logic [31:0] e;
      e = expq.pop_front();
      chk(ref_out == e[31:16], "R2/R3 ref_out", ref_out, e[31:16]);
      chk(mic_out == e[15:0], "R2/R3 mic_out", mic_out, e[15:0]);
    end
  end

  task automatic do_reset(input logic [1:0] m, input logic s);
    @(negedge clk);
    rst_n = 0; cfg_mode = m; cfg_sel = s;
    repeat (2) @(negedge clk);
    hist.delete(); expq.delete(); mdly = 0;
    rst_n = 1;
  endtask

  task automatic smp();
    logic [15:0] r, m, d;
    int n;
    r = 16'(seq * 7 + 3); m = 16'(16'hA000 - seq * 13); seq++;
    hist.push_back(cfg_sel ? m : r);
    n = hist.size() - 1;
    d = (n >= mdly) ? hist[n - mdly] : 16'h0;
    expq.push_back(cfg_sel ? {r, d} : {d, m});
    smp_en = 1; ref_in = r; mic_in = m;
    @(negedge clk);
    smp_en = 0;
    @(negedge clk);
  endtask

  task automatic ack(input int v, input bit loads);
    est_ack = 1; est_val = 12'(v);
    @(negedge clk);
    est_ack = 0;
    if (loads) mdly = clampv(v);
  endtask

  task automatic fix(input int v);
    fix_wr = 1; fix_val = 12'(v);
    @(negedge clk);
    fix_wr = 0; mdly = clampv(v);
  endtask

  initial begin
    #(4 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset(2'b00, 0);
    chk(cur_dly == 0, "R9 reset cur_dly", cur_dly, 0);
    @(negedge clk);
    chk(est_req == 1, "R6 boot request", est_req, 1);
    ack(5, 1);
    chk(est_req == 0, "R6 request drops", est_req, 0);
    repeat (12) smp();
    chk(cur_dly == 5, "R9 cur_dly", cur_dly, 5);
    ack(9, 0);
    repeat (4) smp();
    chk(cur_dly == 5, "R7 stray ack ignored", cur_dly, 5);
    repeat (3) @(negedge clk);
    chk(est_req == 0, "R6 no second request", est_req, 0);
    trig = 1; @(negedge clk); trig = 0;
    chk(est_req == 1, "R6 trigger request", est_req, 1);
    ack(3, 1);
    repeat (6) smp();
    chk(cur_dly == 3, "R6 triggered value", cur_dly, 3);
    fix(3000);
    smp();
    chk(cur_dly == 2400, "R1 clamp", cur_dly, 2400);
    repeat (3) smp();
    fix(0);
    repeat (4) smp();
    chk(cur_dly == 0, "R8 fixed zero", cur_dly, 0);

    do_reset(2'b01, 0);
    @(negedge clk);
    chk(est_req == 1, "R4 continuous request", est_req, 1);
    ack(4, 1);
    chk(est_req == 1, "R4 request stays", est_req, 1);
    repeat (8) smp();
    ack(7, 1);
    repeat (10) smp();
    chk(cur_dly == 7, "R4 second estimate", cur_dly, 7);

    do_reset(2'b10, 0);
    repeat (5) @(negedge clk);
    chk(est_req == 0, "R5 idle after reset", est_req, 0);
    repeat (3) smp();
    trig = 1; @(negedge clk); trig = 0;
    chk(est_req == 1, "R5 trigger request", est_req, 1);
    ack(2, 1);
    chk(est_req == 0, "R5 request drops", est_req, 0);
    repeat (6) smp();
    chk(cur_dly == 2, "R5 loaded", cur_dly, 2);

    do_reset(2'b10, 1);
    fix(6);
    repeat (12) smp();
    chk(cur_dly == 6, "R8 fixed load", cur_dly, 6);

    do_reset(2'b10, 0);
    fix(2400);
    repeat (2410) smp();
    chk(cur_dly == 2400, "R1 full range", cur_dly, 2400);
    chk(expq.size() == 0, "R10 all outputs seen", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule